// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves 18-bit words between two sides, called A and B, through two independent lanes: one carries A inputs to the B outputs, the other carries B inputs to the A outputs. Each lane holds one storage element that can work in three ways. It can pass data straight through like an open latch, hold a stored word, or capture a fresh word on a rising edge of that lane's own capture clock. A capture clock-enable qualifies that edge.

The bidirectional pins are split into an input vector, an output vector and an output-drive flag for each side, so the block stays synthesizable without tristate cells. The lane capture clocks are sampled by the system clock. A rising edge is a low-to-high change between two consecutive system-clock samples. The system clock also carries a synchronous active-high reset.

Top module: `dual_path_xcvr`

## Requirements
- R1: Each side has an 18-bit input vector, an 18-bit output vector and a one-bit drive flag. The A-to-B lane and the B-to-A lane each use their own pass, capture-clock, clock-enable and drive-enable inputs.
- R2: While a lane's pass input is 1, its output equals its input in the same cycle, with no clock edge needed.
- R3: While the pass input is 1, the stored word follows the input at every system-clock edge. When pass returns to 0, the output keeps the word the input had at the last system-clock edge with pass at 1.
- R4: With pass at 0 and no qualified capture edge, the stored word and the output stay unchanged, even when the input changes.
- R5: With pass at 0, a capture-clock sample of 1 after a sample of 0, with clock-enable at 0 (active low), loads the input into storage. The output shows that word from the next system-clock edge onward.
- R6: With clock-enable at 1, a rising capture-clock edge leaves the stored word unchanged.
- R7: The drive-enable input is active low. At 1 the side's output vector is all zeros and its drive flag is 0. At 0 the flag is 1 and the lane's value is driven.
- R8: The two lanes are independent. Both may drive at once, and activity on one never changes the other's output.
- R9: Synchronous reset clears both stored words to zero. It also records each capture clock as already high, so a capture clock held at 1 through the release of reset does not load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on side A |
| a_out | output | 18 | Data driven onto side A (B-to-A lane) |
| a_drive | output | 1 | Side A driving flag |
| b_in | input | 18 | Data arriving on side B |
| b_out | output | 18 | Data driven onto side B (A-to-B lane) |
| b_drive | output | 1 | Side B driving flag |
| ab_pass | input | 1 | A-to-B pass (transparent) control |
| ab_cap_clk | input | 1 | A-to-B capture clock |
| ab_cap_en_n | input | 1 | A-to-B capture clock-enable, active low |
| ab_drv_n | input | 1 | A-to-B drive enable onto side B, active low |
| ba_pass | input | 1 | B-to-A pass (transparent) control |
| ba_cap_clk | input | 1 | B-to-A capture clock |
| ba_cap_en_n | input | 1 | B-to-A capture clock-enable, active low |
| ba_drv_n | input | 1 | B-to-A drive enable onto side A, active low |

## Verification
The assertions watch every cycle that storage follows the input while pass is high, loads on a qualified edge, and stays put with no qualified edge or with clock-enable high. They also check that open lanes show their input, that disabled sides drive zeros with the flag low, and that reset leaves zero storage. Two behaviours only the bench's scenarios can show. One is that a capture clock held high through reset release does not load. The other is that the two lanes stay independent when both drive different data at once. A behavioural model compares all four outputs each cycle, through directed sequences and then a long mixed random run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int XCVR_DEFAULT_W = 18;

    // Per-lane control bundle
    typedef struct packed {
        logic pass;      // transparent when 1
        logic cap_clk;   // capture clock, sampled by the system clock
        logic cap_en_n;  // capture qualifier, active low
        logic drv_n;     // output drive enable, active low
    } lane_ctrl_t;

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic rst,
    input  logic cap_clk,
    input  logic cap_en_n,
    output logic fire
);
    typedef struct packed {
        logic clk_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = cap_clk;
        if (rst) begin
            // Treat the capture clock as already high, so no false edge at release
            st_d.clk_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fire = cap_clk & ~st_q.clk_prev & ~cap_en_n;

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic         fire,
    input  logic [W-1:0] din,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] word;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.word = '0;
        end else if (pass || fire) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.word;

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int W = 18
) (
    input  logic         pass,
    input  logic         drv_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] word,
    output logic [W-1:0] dout,
    output logic         dout_on
);
    logic [W-1:0] sel_d;

    always_comb begin
        sel_d   = pass ? din : word;
        dout_on = ~drv_n;
        dout    = drv_n ? '0 : sel_d;
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  xcvr_pkg::lane_ctrl_t  ctrl,
    input  logic [W-1:0]          din,
    output logic [W-1:0]          dout,
    output logic                  dout_on
);
    logic         fire;
    logic [W-1:0] word;

    xcvr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .cap_clk  (ctrl.cap_clk),
        .cap_en_n (ctrl.cap_en_n),
        .fire     (fire)
    );

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .pass (ctrl.pass),
        .fire (fire),
        .din  (din),
        .word (word)
    );

    xcvr_drive #(.W(W)) u_drive (
        .pass    (ctrl.pass),
        .drv_n   (ctrl.drv_n),
        .din     (din),
        .word    (word),
        .dout    (dout),
        .dout_on (dout_on)
    );

    // R2: an open, driving lane shows its input
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pass && !ctrl.drv_n) |-> (dout == din));

    // R3: storage follows the input while open
    a_r3_track: assert property (@(posedge clk) disable iff (rst)
        ctrl.pass |=> (word == $past(din)));

    // R4: no qualified edge while closed keeps storage
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && !fire) |=> (word == $past(word)));

    // R5: a qualified edge while closed loads the input
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && fire) |=> (word == $past(din)));

    // R6: clock-enable high blocks any load while closed
    a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && ctrl.cap_en_n) |=> (word == $past(word)));

    // R7: a disabled side drives zeros with its flag low
    a_r7_hiz: assert property (@(posedge clk) disable iff (rst)
        ctrl.drv_n |-> (!dout_on && dout == '0));

    // R9: reset leaves a cleared store
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (word == '0));

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
    parameter int DATA_W = xcvr_pkg::XCVR_DEFAULT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    input  logic              ab_pass,
    input  logic              ab_cap_clk,
    input  logic              ab_cap_en_n,
    input  logic              ab_drv_n,
    input  logic              ba_pass,
    input  logic              ba_cap_clk,
    input  logic              ba_cap_en_n,
    input  logic              ba_drv_n
);
    localparam int NLANE = 2;

    xcvr_pkg::lane_ctrl_t ctrl   [NLANE];
    logic [DATA_W-1:0]    l_in   [NLANE];
    logic [DATA_W-1:0]    l_out  [NLANE];
    logic                 l_on   [NLANE];

    // Lane 0 carries A to B, lane 1 carries B to A
    always_comb begin
        ctrl[0] = '{pass: ab_pass, cap_clk: ab_cap_clk, cap_en_n: ab_cap_en_n, drv_n: ab_drv_n};
        ctrl[1] = '{pass: ba_pass, cap_clk: ba_cap_clk, cap_en_n: ba_cap_en_n, drv_n: ba_drv_n};
        l_in[0] = a_in;
        l_in[1] = b_in;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        xcvr_lane #(.W(DATA_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl[g]),
            .din     (l_in[g]),
            .dout    (l_out[g]),
            .dout_on (l_on[g])
        );
    end

    assign b_out   = l_out[0];
    assign b_drive = l_on[0];
    assign a_out   = l_out[1];
    assign a_drive = l_on[1];

endmodule

// File: tb/dual_path_xcvr_bench.sv
module dual_path_xcvr_bench;
    localparam int CLK_P = 10;
    localparam int W     = 18;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_drive, b_drive;
    logic ab_pass, ab_cap_clk, ab_cap_en_n, ab_drv_n;
    logic ba_pass, ba_cap_clk, ba_cap_en_n, ba_drv_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference state
    logic [W-1:0] m_ab_word, m_ba_word;
    bit           m_ab_prev, m_ba_prev;

    always #(CLK_P/2) clk = ~clk;

    dual_path_xcvr u_dual_path_xcvr (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_pass(ab_pass), .ab_cap_clk(ab_cap_clk), .ab_cap_en_n(ab_cap_en_n), .ab_drv_n(ab_drv_n),
        .ba_pass(ba_pass), .ba_cap_clk(ba_cap_clk), .ba_cap_en_n(ba_cap_en_n), .ba_drv_n(ba_drv_n)
    );

    task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h t=%0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare all outputs, then advance the model across one clock edge
    task automatic step(string tag);
        logic [W-1:0] exp_b, exp_a;
        #1;
        exp_b = ab_drv_n ? '0 : (ab_pass ? a_in : m_ab_word);
        exp_a = ba_drv_n ? '0 : (ba_pass ? b_in : m_ba_word);
        chk(tag, "b_out",   b_out,          exp_b);
        chk(tag, "b_drive", {17'd0, b_drive}, {17'd0, ~ab_drv_n});
        chk(tag, "a_out",   a_out,          exp_a);
        chk(tag, "a_drive", {17'd0, a_drive}, {17'd0, ~ba_drv_n});
        @(posedge clk);
        if (rst) begin
            m_ab_word = '0; m_ba_word = '0;
            m_ab_prev = 1;  m_ba_prev = 1;
        end else begin
            if (ab_pass || (ab_cap_clk && !m_ab_prev && !ab_cap_en_n)) m_ab_word = a_in;
            if (ba_pass || (ba_cap_clk && !m_ba_prev && !ba_cap_en_n)) m_ba_word = b_in;
            m_ab_prev = ab_cap_clk;
            m_ba_prev = ba_cap_clk;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_ab_word = 'x; m_ba_word = 'x; m_ab_prev = 1; m_ba_prev = 1;
        rst = 1; a_in = '0; b_in = '0;
        ab_pass = 0; ab_cap_clk = 0; ab_cap_en_n = 1; ab_drv_n = 1;
        ba_pass = 0; ba_cap_clk = 0; ba_cap_en_n = 1; ba_drv_n = 1;
        @(negedge clk);
        @(posedge clk);
        m_ab_word = '0; m_ba_word = '0;
        @(negedge clk);
        step("R9");
        rst = 0;
        // R9: reset state, both sides driving stored zeros
        ab_drv_n = 0; ba_drv_n = 0; a_in = 18'h3F00F; b_in = 18'h00FF0;
        step("R9");
        // R7: drive disabled gives zeros and a low flag
        ab_drv_n = 1; ab_pass = 1;
        step("R7");
        ab_drv_n = 0;
        // R2: open lane, several patterns
        a_in = 18'h3FFFF; step("R2");
        a_in = 18'h12345; step("R2");
        a_in = 18'h2AAAA; step("R2");
        // R3: close the lane, value held as last open word
        ab_pass = 0; step("R3");
        a_in = 18'h15555; step("R3");
        step("R3");
        // R5: qualified rising edge loads
        ab_cap_en_n = 0; ab_cap_clk = 1; step("R5");
        step("R5");
        ab_cap_clk = 0; a_in = 18'h00F0F; step("R5");
        ab_cap_clk = 1; step("R5");
        step("R5");
        // R4: clock held high, input moves, no load
        a_in = 18'h3C3C3; step("R4");
        a_in = 18'h00001; step("R4");
        ab_cap_clk = 0; step("R4");
        // R6: clock-enable high blocks the edge
        ab_cap_en_n = 1; a_in = 18'h20000; step("R6");
        ab_cap_clk = 1; step("R6");
        step("R6");
        // R8: both lanes at once with differing data
        ab_cap_clk = 0; ba_pass = 1; b_in = 18'h0ABCD; ab_pass = 1; a_in = 18'h1DCBA;
        step("R8");
        ba_pass = 0; b_in = 18'h11111; step("R8");
        ba_cap_en_n = 0; ba_cap_clk = 1; a_in = 18'h07777; step("R8");
        step("R8");
        ab_pass = 0; ab_drv_n = 1; ba_cap_clk = 0; b_in = 18'h22222; step("R8");
        ab_drv_n = 0; step("R1");
        // R9: capture clock high through reset release must not load
        ab_cap_clk = 1; ab_cap_en_n = 0; ab_pass = 0; rst = 1; step("R9");
        rst = 0; a_in = 18'h00005; step("R9");
        step("R9");
        step("R9");
        // Mixed random run on both lanes
        for (int i = 0; i < 400; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            {ab_pass, ab_cap_clk, ab_cap_en_n, ab_drv_n} = 4'($urandom);
            {ba_pass, ba_cap_clk, ba_cap_en_n, ba_drv_n} = 4'($urandom);
            rst = ($urandom % 50) == 0;
            step("R8");
        end
        rst = 0;
        step("R8");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule